// File: doc/BRIEF.md
# Register-Launched Serial Flash Command Engine

This block is a host-side serial flash master driven through eight byte-wide registers. Software first loads an opcode, two low address bytes and up to four data bytes. It then writes a mode byte, and that single write launches one SPI frame. The upper nibble of the mode byte picks one of eleven fixed frame shapes. The lower nibble supplies address bits 19:16, so flash addressing is limited to 20 bits.

During the frame the engine drives chip select, the serial clock and MOSI. It stores the bytes it reads from MISO back into the data registers, where software picks them up once the busy flag drops. The serial clock rate comes from an integer divider input.

The register write port is a plain strobe with no handshake. While a frame is in flight the port does not stall the host. It discards every write, so software polls busy before it touches the registers.

Top module: `flash_cmd_engine`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, busy and err are 0, and all eight registers read as 0x00.
- R2: Registers sit at byte offsets: 0 holds the opcode, 1 the mode byte, 2 address bits 15:8, 3 address bits 7:0, and 4 to 7 data bytes 0 to 3. A host write stores wr_data at wr_addr, and rd_data shows the register at rd_addr in the same cycle. Offset 1 reads back the last accepted mode byte.
- R3: A write to offset 1 whose upper nibble is 1 to 0xB starts exactly one frame. Busy is 1 from the next cycle until the cycle in which chip select returns high, and busy always equals the inverse of chip select.
- R4: A mode nibble of 0 or 0xC to 0xF starts no frame, leaves offset 1 unchanged and sets err. Err stays set until the next accepted mode write, which clears it.
- R5: Host writes to any offset while busy is 1 have no effect.
- R6: The bus uses SPI mode 0 with the MSB of each byte first. MOSI changes only while the serial clock is low. Every clock level, the lead-in from chip select falling to the first rising edge, and the tail from the last falling edge to chip select rising each last clk_div+1 system cycles.
- R7: Nibbles 4 to 0xB send three address bytes after the opcode: {4'b0000, mode bits 3:0}, then offset 2, then offset 3. Nibbles 1 to 3 send no address.
- R8: Write bytes come from offset 4 upward. Nibbles 2 and 5 send one write byte and nibble 6 sends four.
- R9: Nibble 3 reads two bytes right after the opcode. Nibble 7 sends a 0x00 dummy byte after the address and then reads four bytes. Nibbles 8, 9, 0xA and 0xB read nibble-7 bytes after the address.
- R10: Read bytes are stored at offsets 4 upward in arrival order, and data registers beyond the read count keep their values. MOSI is 0 during dummy and read bytes.
- R11: A frame carries exactly 8 times its byte count of serial clock pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 3 | Register offset for a write |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Register offset for a read |
| rd_data | output | 8 | Register contents at rd_addr |
| clk_div | input | DIVW | Half-period of the serial clock, minus one, in system cycles |
| busy | output | 1 | Frame in progress |
| err | output | 1 | Sticky flag for a rejected mode write |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
On every cycle the assertions check the following:
- Operand registers and the mode byte stay frozen while busy.
- A rejected mode write raises err and leaves the mode byte alone.
- The serial clock moves only on a divider tick and stays low outside a frame.
- MOSI holds steady while the clock is high.
- Captures happen only inside a frame.

Only the bench scenarios can show the content of a frame. These cover the exact byte order for each of the eleven shapes, the placement of the 20-bit address, the dummy-byte insertion, read bytes landing in the right registers while the others are untouched, and the exact edge spacing for each divider value.

// File: rtl/flash_eng_pkg.sv
package flash_eng_pkg;
  localparam int BYTE_W    = 8;
  localparam int NUM_DATA  = 4;
  localparam int MAX_BYTES = 9;
  localparam int IDX_W     = $clog2(MAX_BYTES);

  // Frame shape picked by the mode nibble
  typedef struct packed {
    logic       ok;
    logic       has_addr;
    logic       dummy;
    logic [2:0] n_wr;
    logic [2:0] n_rd;
  } shape_t;

  function automatic shape_t decode_shape(input logic [3:0] nib);
    shape_t s;
    s = '0;
    case (nib)
      4'h1: s.ok = 1'b1;
      4'h2: begin s.ok = 1'b1; s.n_wr = 3'd1; end
      4'h3: begin s.ok = 1'b1; s.n_rd = 3'd2; end
      4'h4: begin s.ok = 1'b1; s.has_addr = 1'b1; end
      4'h5: begin s.ok = 1'b1; s.has_addr = 1'b1; s.n_wr = 3'd1; end
      4'h6: begin s.ok = 1'b1; s.has_addr = 1'b1; s.n_wr = 3'd4; end
      4'h7: begin s.ok = 1'b1; s.has_addr = 1'b1; s.dummy = 1'b1; s.n_rd = 3'd4; end
      4'h8, 4'h9, 4'hA, 4'hB: begin
        s.ok = 1'b1; s.has_addr = 1'b1; s.n_rd = 3'(nib - 4'd7);
      end
      default: s = '0;
    endcase
    return s;
  endfunction

  // Bytes ahead of the write payload: opcode, address, dummy
  function automatic logic [IDX_W-1:0] head_len(input shape_t s);
    return IDX_W'(1) + (s.has_addr ? IDX_W'(3) : IDX_W'(0)) + IDX_W'(s.dummy);
  endfunction
endpackage

// File: rtl/flash_eng_regs.sv
module flash_eng_regs
  import flash_eng_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [2:0]                       wr_addr,
  input  logic [BYTE_W-1:0]                wr_data,
  input  logic [2:0]                       rd_addr,
  output logic [BYTE_W-1:0]                rd_data,
  input  logic                             busy,
  input  logic                             cap_en,
  input  logic [1:0]                       cap_idx,
  input  logic [BYTE_W-1:0]                cap_data,
  output logic                             start,
  output logic [BYTE_W-1:0]                opcode,
  output logic [BYTE_W-1:0]                addr_hi,
  output logic [BYTE_W-1:0]                addr_lo,
  output logic [NUM_DATA-1:0][BYTE_W-1:0]  data_q,
  output logic                             err
);
  logic [BYTE_W-1:0] mode_q;
  logic              host_wr;
  shape_t            req;

  assign host_wr = wr_en && !busy;
  assign req     = decode_shape(wr_data[7:4]);
  assign start   = host_wr && (wr_addr == 3'd1) && req.ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opcode  <= '0;
      mode_q  <= '0;
      addr_hi <= '0;
      addr_lo <= '0;
      data_q  <= '0;
      err     <= 1'b0;
    end else begin
      if (host_wr) begin
        case (wr_addr)
          3'd0: opcode <= wr_data;
          3'd1: begin
            if (req.ok) mode_q <= wr_data;
            err <= !req.ok;
          end
          3'd2: addr_hi <= wr_data;
          3'd3: addr_lo <= wr_data;
          default: data_q[wr_addr[1:0]] <= wr_data;
        endcase
      end
      if (cap_en) data_q[cap_idx] <= cap_data;
    end
  end

  always_comb begin
    case (rd_addr)
      3'd0: rd_data = opcode;
      3'd1: rd_data = mode_q;
      3'd2: rd_data = addr_hi;
      3'd3: rd_data = addr_lo;
      default: rd_data = data_q[rd_addr[1:0]];
    endcase
  end

  // R5
  busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(opcode) && $stable(addr_hi) && $stable(addr_lo) && $stable(mode_q));

  // R4
  bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy && wr_addr == 3'd1 && !req.ok) |=> err && $stable(mode_q));

  // R4
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !err);

  // R10
  cap_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |-> busy);
endmodule

// File: rtl/flash_eng_clkgen.sv
module flash_eng_clkgen #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [DIVW-1:0] div,
  output logic            tick
);
  logic [DIVW-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/flash_eng_shifter.sv
module flash_eng_shifter
  import flash_eng_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start,
  input  logic [BYTE_W-1:0]                start_mode,
  input  logic [BYTE_W-1:0]                opcode,
  input  logic [BYTE_W-1:0]                addr_hi,
  input  logic [BYTE_W-1:0]                addr_lo,
  input  logic [NUM_DATA-1:0][BYTE_W-1:0]  data_q,
  input  logic                             tick,
  input  logic                             miso,
  output logic                             busy,
  output logic                             sclk,
  output logic                             cs_n,
  output logic                             mosi,
  output logic                             cap_en,
  output logic [1:0]                       cap_idx,
  output logic [BYTE_W-1:0]                cap_data
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_TAIL} st_t;

  st_t               st;
  shape_t            shp;
  logic [3:0]        nib;
  logic [IDX_W-1:0]  bidx, nxt, hdr, n_tx, n_tot;
  logic [2:0]        bit_n;
  logic [BYTE_W-1:0] tx_sh, rx_sh, nxt_byte;

  assign busy  = (st != S_IDLE);
  assign mosi  = tx_sh[BYTE_W-1] & ~cs_n;
  assign hdr   = head_len(shp);
  assign n_tx  = hdr + IDX_W'(shp.n_wr);
  assign n_tot = n_tx + IDX_W'(shp.n_rd);
  assign nxt   = bidx + IDX_W'(1);

  // Byte that follows the current one; dummy and read slots send zero
  always_comb begin
    nxt_byte = '0;
    if (shp.has_addr && nxt == IDX_W'(1))      nxt_byte = {4'h0, nib};
    else if (shp.has_addr && nxt == IDX_W'(2)) nxt_byte = addr_hi;
    else if (shp.has_addr && nxt == IDX_W'(3)) nxt_byte = addr_lo;
    else if (nxt >= hdr && nxt < n_tx)         nxt_byte = data_q[2'(nxt - hdr)];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      shp      <= '0;
      nib      <= '0;
      bidx     <= '0;
      bit_n    <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      sclk     <= 1'b0;
      cs_n     <= 1'b1;
      cap_en   <= 1'b0;
      cap_idx  <= '0;
      cap_data <= '0;
    end else begin
      cap_en <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st    <= S_RUN;
          shp   <= decode_shape(start_mode[7:4]);
          nib   <= start_mode[3:0];
          bidx  <= '0;
          bit_n <= 3'd7;
          tx_sh <= opcode;
          cs_n  <= 1'b0;
          sclk  <= 1'b0;
        end
        S_RUN: if (tick) begin
          if (!sclk) begin
            sclk  <= 1'b1;
            rx_sh <= {rx_sh[BYTE_W-2:0], miso};
          end else begin
            sclk <= 1'b0;
            if (bit_n == 3'd0) begin
              if (bidx >= n_tx) begin
                cap_en   <= 1'b1;
                cap_idx  <= 2'(bidx - n_tx);
                cap_data <= rx_sh;
              end
              if (bidx == n_tot - IDX_W'(1)) st <= S_TAIL;
              else begin
                bidx  <= nxt;
                tx_sh <= nxt_byte;
              end
              bit_n <= 3'd7;
            end else begin
              bit_n <= bit_n - 3'd1;
              tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
            end
          end
        end
        S_TAIL: if (tick) begin
          cs_n <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R3
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n && !sclk);

  // R6
  sclk_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(sclk));

  // R6
  mosi_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |=> !sclk || $stable(mosi));

  // R11
  no_clk_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
  import flash_eng_pkg::*;
#(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [2:0]      wr_addr,
  input  logic [7:0]      wr_data,
  input  logic [2:0]      rd_addr,
  output logic [7:0]      rd_data,
  input  logic [DIVW-1:0] clk_div,
  output logic            busy,
  output logic            err,
  output logic            spi_sclk,
  output logic            spi_cs_n,
  output logic            spi_mosi,
  input  logic            spi_miso
);
  logic                            start, tick, cap_en;
  logic [1:0]                      cap_idx;
  logic [BYTE_W-1:0]               cap_data, opcode, addr_hi, addr_lo;
  logic [NUM_DATA-1:0][BYTE_W-1:0] data_q;

  flash_eng_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .cap_en(cap_en),
    .cap_idx(cap_idx), .cap_data(cap_data), .start(start), .opcode(opcode),
    .addr_hi(addr_hi), .addr_lo(addr_lo), .data_q(data_q), .err(err)
  );

  flash_eng_clkgen #(.DIVW(DIVW)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(clk_div), .tick(tick)
  );

  flash_eng_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .start_mode(wr_data), .opcode(opcode),
    .addr_hi(addr_hi), .addr_lo(addr_lo), .data_q(data_q), .tick(tick),
    .miso(spi_miso), .busy(busy), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .cap_en(cap_en), .cap_idx(cap_idx), .cap_data(cap_data)
  );
endmodule

// File: tb/sim_flash_cmd_engine.sv
module sim_flash_cmd_engine;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [7:0] clk_div = '0;
  logic       busy, err, spi_sclk, spi_cs_n, spi_mosi, spi_miso;

  always #5 clk = ~clk;

  flash_cmd_engine u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .clk_div(clk_div), .busy(busy), .err(err),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int tests = 0, fails = 0;
  logic [7:0] mdl [0:7];
  logic       cap_bits [0:79];
  logic       resp_bits [0:79];
  int cap_n = 0, frames = 0;
  int cur_div = 0, gap = 0, tbad = 0, bbad = 0, mbad = 0;
  logic prev_cs = 1'b1, prev_sclk = 1'b0, prev_mosi = 1'b0;

  assign spi_miso = (cap_n < 80) ? resp_bits[cap_n] : 1'b0;

  // Flash-side model: capture MOSI on rising clock, count frames
  always @(negedge spi_cs_n or posedge spi_sclk) begin
    if (spi_sclk && !spi_cs_n) begin
      if (cap_n < 80) cap_bits[cap_n] = spi_mosi;
      cap_n = cap_n + 1;
    end else if (!spi_cs_n) begin
      cap_n  = 0;
      frames = frames + 1;
    end
  end

  // Edge spacing, busy/cs agreement, MOSI hold
  always @(negedge clk) begin
    if (rst_n) begin
      if (!prev_cs) gap = gap + 1;
      if (prev_cs && !spi_cs_n) gap = 0;
      else if (!prev_cs && spi_cs_n) begin
        if (gap != cur_div + 1) tbad = tbad + 1;
      end else if (!spi_cs_n && spi_sclk != prev_sclk) begin
        if (gap != cur_div + 1) tbad = tbad + 1;
        gap = 0;
      end
      if (busy !== !spi_cs_n) bbad = bbad + 1;
      if (prev_sclk && spi_sclk && spi_mosi !== prev_mosi) mbad = mbad + 1;
    end
    prev_cs = spi_cs_n; prev_sclk = spi_sclk; prev_mosi = spi_mosi;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic read_reg(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); rd_addr = a; #1 v = rd_data;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 6000 && busy; i++) @(negedge clk);
    chk(!busy, "R3 frame end", busy, 0);
  endtask

  // Expected frame from the requirement text
  task automatic run_txn(input logic [3:0] m, input logic [3:0] an, input int dv);
    int adr, dmy, nw, nr, len, ntx, f0, t0, b0, m0;
    logic [7:0] eb [0:8];
    logic [7:0] v, got;
    adr = (m >= 4) ? 1 : 0; dmy = (m == 7) ? 1 : 0;
    nw  = (m == 2 || m == 5) ? 1 : (m == 6) ? 4 : 0;
    nr  = (m == 3) ? 2 : (m == 7) ? 4 : (m >= 8) ? m - 7 : 0;
    for (int a = 0; a < 8; a++) begin
      if (a != 1) begin
        v = 8'($urandom); host_write(3'(a), v); mdl[a] = v;
      end
    end
    cur_div = dv; clk_div = 8'(dv);
    for (int i = 0; i < 80; i++) resp_bits[i] = 1'($urandom);
    len = 0;
    eb[len] = mdl[0]; len++;
    if (adr == 1) begin
      eb[len] = {4'h0, an}; len++; eb[len] = mdl[2]; len++; eb[len] = mdl[3]; len++;
    end
    if (dmy == 1) begin eb[len] = 8'h00; len++; end
    for (int i = 0; i < nw; i++) begin eb[len] = mdl[4 + i]; len++; end
    ntx = len;
    for (int i = 0; i < nr; i++) begin eb[len] = 8'h00; len++; end
    f0 = frames; t0 = tbad; b0 = bbad; m0 = mbad;
    host_write(3'd1, {m, an});
    chk(busy == 1'b1, "R3 busy after launch", busy, 1);
    wait_idle();
    repeat (3) @(negedge clk);
    mdl[1] = {m, an};
    chk(frames == f0 + 1, "R3 one frame", frames - f0, 1);
    chk(cap_n == 8 * len, "R11 clock pulses", cap_n, 8 * len);
    for (int b = 0; b < len; b++) begin
      for (int k = 0; k < 8; k++) got[7 - k] = cap_bits[8 * b + k];
      // R7 address, R8 write bytes, R9 dummy, R10 zero MOSI in reads
      chk(got == eb[b], (b < ntx) ? "R7/R8 byte on MOSI" : "R10 MOSI in read", got, eb[b]);
    end
    for (int i = 0; i < nr; i++)
      for (int k = 0; k < 8; k++) mdl[4 + i][7 - k] = resp_bits[8 * (ntx + i) + k];
    chk(tbad == t0, "R6 edge spacing", tbad - t0, 0);
    chk(bbad == b0, "R3 busy vs cs", bbad - b0, 0);
    chk(mbad == m0, "R6 MOSI hold", mbad - m0, 0);
    for (int a = 0; a < 8; a++) begin
      read_reg(3'(a), got);
      chk(got == mdl[a], (a >= 4) ? "R9/R10 data regs" : "R2 readback", got, mdl[a]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int f0;
    void'($urandom(32'h1F2E3D4C));
    for (int a = 0; a < 8; a++) mdl[a] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R1 bus idle", {spi_cs_n, spi_sclk}, 2);
    chk(busy == 1'b0 && err == 1'b0, "R1 flags", {busy, err}, 0);
    for (int a = 0; a < 8; a++) begin
      read_reg(3'(a), v); chk(v == 8'h00, "R1 regs clear", v, 0);
    end

    // Every shape at two divider settings
    for (int m = 1; m <= 11; m++) run_txn(4'(m), 4'(m + 3), 0);
    for (int m = 1; m <= 11; m++) run_txn(4'(m), 4'hF - 4'(m), 2);

    // R4 rejected nibbles
    f0 = frames;
    host_write(3'd1, 8'h05);
    chk(err == 1'b1 && busy == 1'b0, "R4 nibble 0 rejected", {err, busy}, 2);
    host_write(3'd1, 8'hD3);
    repeat (10) @(negedge clk);
    chk(frames == f0 && spi_cs_n == 1'b1, "R4 no frame", frames - f0, 0);
    chk(err == 1'b1, "R4 err sticky", err, 1);
    read_reg(3'd1, v); chk(v == mdl[1], "R4 mode kept", v, mdl[1]);
    run_txn(4'h4, 4'h9, 1);
    chk(err == 1'b0, "R4 err cleared", err, 0);

    // R5 writes while busy
    clk_div = 8'd3; cur_div = 3;
    host_write(3'd1, 8'h62);
    mdl[1] = 8'h62;
    host_write(3'd0, ~mdl[0]);
    host_write(3'd4, ~mdl[4]);
    host_write(3'd2, ~mdl[2]);
    f0 = frames;
    host_write(3'd1, 8'h10);
    wait_idle();
    repeat (20) @(negedge clk);
    chk(frames == f0, "R5 no second frame", frames - f0, 0);
    for (int a = 0; a < 5; a++) begin
      read_reg(3'(a), v); chk(v == mdl[a], "R5 reg unchanged", v, mdl[a]);
    end

    // Random mix
    for (int n = 0; n < 24; n++)
      run_txn(4'(1 + $urandom % 11), 4'($urandom), int'($urandom % 4));

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule